// File: doc/BRIEF.md
# Rename Buffer Register File

This block is the integer register storage of a superscalar core that runs instructions out of order. It combines 32 committed 64-bit architectural registers with a small circular pool of rename entries. Each instruction that writes a register receives a rename entry when it issues. Its result goes into that entry when it completes, and it is copied into the architectural register when the instruction retires in program order. A flush throws away every speculative entry in one cycle.

Source operands are looked up in the combined space of architectural and rename registers. A lookup returns one of three things: the committed value; a finished speculative value; or the tag of a result that is still outstanding, with the ready flag low, so that the issue logic can wait for it on the result bus. Up to four instructions may be issued, four results written and four instructions retired in each clock. Each issue slot carries one operand lookup, and that lookup sees the destinations of older slots issued in the same cycle.

Top module: `rename_regfile`

## Requirements
- R1: After reset, every register reads as ready with value zero, all 8 rename entries are free, and the first tag handed out is 0.
- R2: Requests are granted in slot order. Tags (0 to 7) are consecutive modulo 8, starting at the oldest free entry. No more grants are given than there are free entries, and once the pool is full all requests are refused. Grants never exceed the requests.
- R3: A lookup of a register with no pending writer returns its committed value with ready high.
- R4: A lookup of a register whose youngest pending writer has not produced its result returns ready low and that writer's tag.
- R5: When an earlier slot in the same cycle is granted an entry for the register that a later slot looks up, the later slot receives ready low and that earlier slot's new tag. The youngest such earlier slot wins.
- R6: A result write stores its data in the tagged entry. From the next cycle, lookups of that register return the data with ready high.
- R7: The commit count input asks to retire up to that many of the oldest entries. The block retires the longest run of finished entries, oldest first, within that limit and reports how many it retired. The retired values then read as committed values, and the entries become free again.
- R8: Retiring an entry leaves the register mapped to any younger pending writer. A lookup then still returns that writer's tag.
- R9: A flush frees every uncommitted entry and removes every pending mapping, and leaves committed values unchanged. Allocations, writes and commits presented in the same cycle are ignored. The next cycle offers the full pool, starting at the oldest entry position.
- R10: Register 0 is renamed, written and read like any other register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Discard all speculative state |
| alloc_req | input | 4 | Per-slot request for a rename entry |
| alloc_rd | input | 4x5 | Per-slot destination register |
| alloc_gnt | output | 4 | Per-slot grant |
| alloc_tag | output | 4x3 | Per-slot granted rename tag |
| src_reg | input | 4x5 | Per-slot source register to look up |
| src_ready | output | 4 | Source value available |
| src_tag | output | 4x3 | Rename tag to wait on when not ready |
| src_data | output | 4x64 | Source value when ready |
| wr_en | input | 4 | Per-port result write enable |
| wr_tag | input | 4x3 | Rename tag being written |
| wr_data | input | 4x64 | Result value |
| commit_num | input | 3 | Number of oldest entries asked to retire (0 to 4) |
| commit_cnt | output | 3 | Number actually retired this cycle |

## Verification
A stale or lost mapping shows up on the very next lookup of that register: the ready flag is wrong, the tag points at the wrong entry, or the value read back is an older one. A head or tail pointer that has drifted shows up in the same cycle as wrong grant tags. It shows up again once the pool fills, as wrong grant counts. A value copied wrongly at commit stays hidden while a younger writer still holds the mapping. It appears when that register next reads its committed value, which can be many cycles later. For that reason the random traffic uses only a few registers and flushes often.

// File: rtl/rbrf_pkg.sv
// Package: shared types for the rename buffer register file.
// Assumes nothing beyond IEEE 1800-2017 packages.
package rbrf_pkg;

    // Where a slot's operand was resolved from.
    typedef enum logic [1:0] {
        SRC_ARCH = 2'd0,
        SRC_PEND = 2'd1,
        SRC_DONE = 2'd2,
        SRC_SAME = 2'd3
    } src_kind_e;

endpackage

// File: rtl/rbrf_alloc.sv
// Module: rbrf_alloc
// Grants rename entries to issue slots in slot order, bounded by the free
// count, and hands out consecutive tags from the tail pointer.
// Assumes NREN is a power of two so the tag wraps naturally.
module rbrf_alloc #(
    parameter int W    = 4,
    parameter int NREN = 8,
    localparam int TW  = $clog2(NREN),
    localparam int OW  = TW + 1,
    localparam int CW  = $clog2(W + 1)
) (
    input  logic [W-1:0]         req,
    input  logic [OW-1:0]        occ,
    input  logic [TW-1:0]        tail,
    output logic [W-1:0]         gnt,
    output logic [W-1:0][TW-1:0] tag,
    output logic [CW-1:0]        n_alloc
);

    logic [OW-1:0] free_slots;

    // Free entries available this cycle.
    assign free_slots = OW'(NREN) - occ;

    // Walk slots in order, granting while free entries remain.
    always_comb begin
        int cnt;
        cnt = 0;
        for (int k = 0; k < W; k++) begin
            gnt[k] = 1'b0;
            tag[k] = tail + TW'(cnt);
            if (req[k] && (OW'(cnt) < free_slots)) begin
                gnt[k] = 1'b1;
                cnt    = cnt + 1;
            end
        end
        n_alloc = CW'(cnt);
    end

endmodule

// File: rtl/rbrf_commit.sv
// Module: rbrf_commit
// Picks the longest run of finished entries from the head, up to the
// requested count, and reports their indices for retirement.
// Assumes occ never exceeds NREN.
module rbrf_commit #(
    parameter int W    = 4,
    parameter int NREN = 8,
    localparam int TW  = $clog2(NREN),
    localparam int OW  = TW + 1,
    localparam int CW  = $clog2(W + 1)
) (
    input  logic [CW-1:0]        num,
    input  logic [OW-1:0]        occ,
    input  logic [TW-1:0]        head,
    input  logic [NREN-1:0]      done,
    output logic [W-1:0]         vld,
    output logic [W-1:0][TW-1:0] idx,
    output logic [CW-1:0]        cnt
);

    // Scan from the head; stop at the first unfinished or absent entry.
    always_comb begin
        logic run;
        int   c;
        run = 1'b1;
        c   = 0;
        for (int k = 0; k < W; k++) begin
            idx[k] = head + TW'(k);
            vld[k] = 1'b0;
            if (run && (CW'(k) < num) && (OW'(k) < occ) && done[idx[k]]) begin
                vld[k] = 1'b1;
                c      = c + 1;
            end else begin
                run = 1'b0;
            end
        end
        cnt = CW'(c);
    end

endmodule

// File: rtl/rbrf_lookup.sv
// Module: rbrf_lookup
// Resolves each slot's source register against same-cycle older grants,
// then the pending mapping, then the committed value.
// Assumes mappings only name entries that are currently allocated.
module rbrf_lookup
    import rbrf_pkg::*;
#(
    parameter int W     = 4,
    parameter int XLEN  = 64,
    parameter int NARCH = 32,
    parameter int NREN  = 8,
    localparam int AW   = $clog2(NARCH),
    localparam int TW   = $clog2(NREN)
) (
    input  logic [W-1:0][AW-1:0]       src,
    input  logic [W-1:0]               gnt,
    input  logic [W-1:0][AW-1:0]       rd,
    input  logic [W-1:0][TW-1:0]       gtag,
    input  logic [NARCH-1:0]           map_v,
    input  logic [NARCH-1:0][TW-1:0]   map_t,
    input  logic [NREN-1:0]            ren_done,
    input  logic [NREN-1:0][XLEN-1:0]  ren_data,
    input  logic [NARCH-1:0][XLEN-1:0] arch,
    output logic [W-1:0]               ready,
    output logic [W-1:0][TW-1:0]       tag,
    output logic [W-1:0][XLEN-1:0]     data
);

    src_kind_e kind [W];

    // Classify every slot's operand, youngest older slot overriding.
    always_comb begin
        for (int k = 0; k < W; k++) begin
            tag[k] = map_t[src[k]];
            if (map_v[src[k]]) begin
                kind[k] = ren_done[map_t[src[k]]] ? SRC_DONE : SRC_PEND;
            end else begin
                kind[k] = SRC_ARCH;
            end
            for (int j = 0; j < W; j++) begin
                if ((j < k) && gnt[j] && (rd[j] == src[k])) begin
                    kind[k] = SRC_SAME;
                    tag[k]  = gtag[j];
                end
            end
        end
    end

    // Produce ready flag and value from the classification.
    always_comb begin
        for (int k = 0; k < W; k++) begin
            unique case (kind[k])
                SRC_ARCH: begin ready[k] = 1'b1; data[k] = arch[src[k]];     end
                SRC_DONE: begin ready[k] = 1'b1; data[k] = ren_data[tag[k]]; end
                default:  begin ready[k] = 1'b0; data[k] = '0;               end
            endcase
        end
    end

endmodule

// File: rtl/rename_regfile.sv
// Module: rename_regfile
// Architectural register file plus a circular rename pool. Issue allocates
// entries in order, results land in entries out of order, retirement copies
// entries into the architectural file in order, flush drops speculation.
// Assumes the caller writes only allocated, unfinished tags.
module rename_regfile #(
    parameter int XLEN  = 64,
    parameter int NARCH = 32,
    parameter int NREN  = 8,
    parameter int W     = 4,
    localparam int AW   = $clog2(NARCH),
    localparam int TW   = $clog2(NREN),
    localparam int OW   = TW + 1,
    localparam int CW   = $clog2(W + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   flush,
    input  logic [W-1:0]           alloc_req,
    input  logic [W-1:0][AW-1:0]   alloc_rd,
    output logic [W-1:0]           alloc_gnt,
    output logic [W-1:0][TW-1:0]   alloc_tag,
    input  logic [W-1:0][AW-1:0]   src_reg,
    output logic [W-1:0]           src_ready,
    output logic [W-1:0][TW-1:0]   src_tag,
    output logic [W-1:0][XLEN-1:0] src_data,
    input  logic [W-1:0]           wr_en,
    input  logic [W-1:0][TW-1:0]   wr_tag,
    input  logic [W-1:0][XLEN-1:0] wr_data,
    input  logic [CW-1:0]          commit_num,
    output logic [CW-1:0]          commit_cnt
);

    logic [NARCH-1:0][XLEN-1:0] arch_q;
    logic [NARCH-1:0]           map_v_q;
    logic [NARCH-1:0][TW-1:0]   map_t_q;
    logic [NREN-1:0][XLEN-1:0]  ren_data_q;
    logic [NREN-1:0]            ren_done_q;
    logic [NREN-1:0][AW-1:0]    ren_areg_q;
    logic [TW-1:0]              head_q, tail_q;
    logic [OW-1:0]              occ_q;

    logic [CW-1:0]              n_alloc;
    logic [W-1:0]               cmt_vld;
    logic [W-1:0][TW-1:0]       cmt_idx;
    logic [W-1:0][AW-1:0]       cmt_areg;

    rbrf_alloc #(.W(W), .NREN(NREN)) u_alloc (
        .req     (alloc_req),
        .occ     (occ_q),
        .tail    (tail_q),
        .gnt     (alloc_gnt),
        .tag     (alloc_tag),
        .n_alloc (n_alloc)
    );

    rbrf_commit #(.W(W), .NREN(NREN)) u_commit (
        .num  (commit_num),
        .occ  (occ_q),
        .head (head_q),
        .done (ren_done_q),
        .vld  (cmt_vld),
        .idx  (cmt_idx),
        .cnt  (commit_cnt)
    );

    rbrf_lookup #(.W(W), .XLEN(XLEN), .NARCH(NARCH), .NREN(NREN)) u_lookup (
        .src      (src_reg),
        .gnt      (alloc_gnt),
        .rd       (alloc_rd),
        .gtag     (alloc_tag),
        .map_v    (map_v_q),
        .map_t    (map_t_q),
        .ren_done (ren_done_q),
        .ren_data (ren_data_q),
        .arch     (arch_q),
        .ready    (src_ready),
        .tag      (src_tag),
        .data     (src_data)
    );

    // Destination register of each retiring entry.
    generate
        for (genvar g = 0; g < W; g++) begin : g_careg
            assign cmt_areg[g] = ren_areg_q[cmt_idx[g]];
        end
    endgenerate

    // Pool pointers and occupancy; flush rewinds the tail to the head.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
            occ_q  <= '0;
        end else if (flush) begin
            tail_q <= head_q;
            occ_q  <= '0;
        end else begin
            head_q <= head_q + TW'(commit_cnt);
            tail_q <= tail_q + TW'(n_alloc);
            occ_q  <= occ_q - OW'(commit_cnt) + OW'(n_alloc);
        end
    end

    // Rename entry contents: results set data and done, allocation clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ren_data_q <= '0;
            ren_done_q <= '0;
            ren_areg_q <= '0;
        end else if (!flush) begin
            for (int k = 0; k < W; k++) begin
                if (wr_en[k]) begin
                    ren_data_q[wr_tag[k]] <= wr_data[k];
                    ren_done_q[wr_tag[k]] <= 1'b1;
                end
            end
            for (int k = 0; k < W; k++) begin
                if (alloc_gnt[k]) begin
                    ren_areg_q[alloc_tag[k]] <= alloc_rd[k];
                    ren_done_q[alloc_tag[k]] <= 1'b0;
                end
            end
        end
    end

    // Architectural copy at retirement; later slot wins on a shared register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arch_q <= '0;
        end else if (!flush) begin
            for (int k = 0; k < W; k++) begin
                if (cmt_vld[k]) begin
                    arch_q[cmt_areg[k]] <= ren_data_q[cmt_idx[k]];
                end
            end
        end
    end

    // Register mapping: retirement clears only its own mapping, allocation sets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_v_q <= '0;
            map_t_q <= '0;
        end else if (flush) begin
            map_v_q <= '0;
        end else begin
            for (int k = 0; k < W; k++) begin
                if (cmt_vld[k] && map_v_q[cmt_areg[k]] &&
                    (map_t_q[cmt_areg[k]] == cmt_idx[k])) begin
                    map_v_q[cmt_areg[k]] <= 1'b0;
                end
            end
            for (int k = 0; k < W; k++) begin
                if (alloc_gnt[k]) begin
                    map_v_q[alloc_rd[k]] <= 1'b1;
                    map_t_q[alloc_rd[k]] <= alloc_tag[k];
                end
            end
        end
    end

endmodule

// File: rtl/rbrf_chk.sv
// Module: rbrf_chk
// Port-level temporal checks on rename_regfile, attached by bind.
// Assumes W is at least 2.
module rbrf_chk #(
    parameter int W    = 4,
    parameter int NREN = 8,
    parameter int AW   = 5,
    parameter int TW   = 3,
    parameter int CW   = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 flush,
    input logic [W-1:0]         alloc_req,
    input logic [W-1:0]         alloc_gnt,
    input logic [W-1:0][AW-1:0] alloc_rd,
    input logic [W-1:0][TW-1:0] alloc_tag,
    input logic [W-1:0][AW-1:0] src_reg,
    input logic [W-1:0]         src_ready,
    input logic [W-1:0][TW-1:0] src_tag,
    input logic [CW-1:0]        commit_num,
    input logic [CW-1:0]        commit_cnt,
    input logic [TW:0]          occ
);

    p_gnt_subset_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_gnt & ~alloc_req) == '0);

    p_full_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(occ) == NREN) |-> (alloc_gnt == '0));

    p_occ_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        int'(occ) <= NREN);

    p_tag_seq_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_gnt[0] && alloc_gnt[1]) |-> (alloc_tag[1] == alloc_tag[0] + TW'(1)));

    p_same_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_gnt[0] && (src_reg[1] == alloc_rd[0])) |->
        (!src_ready[1] && (src_tag[1] == alloc_tag[0])));

    p_commit_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        commit_cnt <= commit_num);

    p_flush_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> src_ready[0]);

    p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (occ == '0));

endmodule

bind rename_regfile rbrf_chk #(.W(W), .NREN(NREN), .AW(AW), .TW(TW), .CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .alloc_req  (alloc_req),
    .alloc_gnt  (alloc_gnt),
    .alloc_rd   (alloc_rd),
    .alloc_tag  (alloc_tag),
    .src_reg    (src_reg),
    .src_ready  (src_ready),
    .src_tag    (src_tag),
    .commit_num (commit_num),
    .commit_cnt (commit_cnt),
    .occ        (occ_q)
);

// File: tb/sim_rename_regfile.sv
`timescale 1ns/1ps
// Bench: behavioural queue model of the rename pool, compared every cycle.
module sim_rename_regfile;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              flush;
    logic [3:0]        alloc_req;
    logic [3:0][4:0]   alloc_rd;
    logic [3:0]        alloc_gnt;
    logic [3:0][2:0]   alloc_tag;
    logic [3:0][4:0]   src_reg;
    logic [3:0]        src_ready;
    logic [3:0][2:0]   src_tag;
    logic [3:0][63:0]  src_data;
    logic [3:0]        wr_en;
    logic [3:0][2:0]   wr_tag;
    logic [3:0][63:0]  wr_data;
    logic [2:0]        commit_num;
    logic [2:0]        commit_cnt;

    int nchk = 0;
    int nfail = 0;

    typedef struct {
        int          tag;
        int          areg;
        logic [63:0] data;
        bit          done;
    } ent_t;

    ent_t        q[$];
    logic [63:0] arch[32];
    int          head_tag;

    rename_regfile u0 (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .alloc_req(alloc_req), .alloc_rd(alloc_rd),
        .alloc_gnt(alloc_gnt), .alloc_tag(alloc_tag),
        .src_reg(src_reg), .src_ready(src_ready), .src_tag(src_tag), .src_data(src_data),
        .wr_en(wr_en), .wr_tag(wr_tag), .wr_data(wr_data),
        .commit_num(commit_num), .commit_cnt(commit_cnt)
    );

    always #10 clk = ~clk;

    task automatic chk(string rq, string what, logic [63:0] act, logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s act=%h exp=%h t=%0t", rq, what, act, exp, $time);
        end
    endtask

    task automatic idle();
        flush = 0; alloc_req = '0; alloc_rd = '0; src_reg = '0;
        wr_en = '0; wr_tag = '0; wr_data = '0; commit_num = '0;
    endtask

    // Compare outputs for the present inputs, clock once, advance the model.
    task automatic step();
        bit       eg[4];
        int       et[4];
        int       n, c, fwd, idx;
        bit       er;
        int       etag;
        logic [63:0] ed;
        string    lbl;
        #1;
        n = 0;
        for (int k = 0; k < 4; k++) begin
            eg[k] = 0; et[k] = 0;
            if (alloc_req[k] && n < 8 - q.size()) begin
                eg[k] = 1; et[k] = (head_tag + q.size() + n) % 8; n++;
            end
            chk("R2", $sformatf("gnt[%0d]", k), 64'(alloc_gnt[k]), 64'(eg[k]));
            if (eg[k]) chk("R2", $sformatf("tag[%0d]", k), 64'(alloc_tag[k]), 64'(et[k]));
        end
        for (int k = 0; k < 4; k++) begin
            fwd = -1;
            for (int j = 0; j < k; j++)
                if (eg[j] && alloc_rd[j] == src_reg[k]) fwd = j;
            ed = '0; etag = 0;
            if (fwd >= 0) begin
                er = 0; etag = et[fwd]; lbl = "R5";
            end else begin
                idx = -1;
                for (int i = 0; i < q.size(); i++) if (q[i].areg == int'(src_reg[k])) idx = i;
                if (idx >= 0) begin
                    er = q[idx].done; etag = q[idx].tag; ed = q[idx].data;
                    lbl = er ? "R6" : "R4";
                end else begin
                    er = 1; ed = arch[src_reg[k]]; lbl = "R3";
                end
            end
            chk(lbl, $sformatf("ready[%0d]", k), 64'(src_ready[k]), 64'(er));
            if (!er) chk(lbl, $sformatf("srctag[%0d]", k), 64'(src_tag[k]), 64'(etag));
            else     chk(lbl, $sformatf("data[%0d]", k), src_data[k], ed);
        end
        c = 0;
        while (c < int'(commit_num) && c < q.size() && q[c].done) c++;
        chk("R7", "commit_cnt", 64'(commit_cnt), 64'(c));
        @(posedge clk);
        if (flush) begin
            q.delete();
        end else begin
            for (int i = 0; i < c; i++) begin
                arch[q[0].areg] = q[0].data;
                void'(q.pop_front());
            end
            head_tag = (head_tag + c) % 8;
            for (int k = 0; k < 4; k++)
                if (wr_en[k])
                    for (int i = 0; i < q.size(); i++)
                        if (q[i].tag == int'(wr_tag[k])) begin
                            q[i].data = wr_data[k]; q[i].done = 1;
                        end
            for (int k = 0; k < 4; k++)
                if (eg[k]) q.push_back('{tag: et[k], areg: int'(alloc_rd[k]), data: '0, done: 0});
        end
        @(negedge clk);
    endtask

    task automatic peek();
        #1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        idle();
        head_tag = 0;
        for (int i = 0; i < 32; i++) arch[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: reset state read through the lookup ports
        src_reg = {5'd31, 5'd2, 5'd1, 5'd0}; alloc_req = 4'hf;
        peek();
        for (int k = 0; k < 4; k++) begin
            chk("R1", "reset ready", 64'(src_ready[k]), 64'd1);
            chk("R1", "reset data", src_data[k], 64'd0);
        end
        chk("R1", "reset grants", 64'(alloc_gnt), 64'hf);
        chk("R1", "first tag", 64'(alloc_tag[0]), 64'd0);
        idle();

        // R10: register 0 renamed, written, retired
        alloc_req = 4'b0001; alloc_rd[0] = 5'd0; step(); idle();
        wr_en[0] = 1; wr_tag[0] = 3'd0; wr_data[0] = 64'hAB; step(); idle();
        src_reg[0] = 5'd0; peek();
        chk("R10", "r0 rename ready", 64'(src_ready[0]), 64'd1);
        chk("R10", "r0 rename data", src_data[0], 64'hAB);
        commit_num = 3'd1; step(); idle();
        src_reg[0] = 5'd0; peek();
        chk("R10", "r0 committed data", src_data[0], 64'hAB);
        idle();

        // R8: older writer retires, younger pending mapping survives
        alloc_req = 4'b0011; alloc_rd[0] = 5'd5; alloc_rd[1] = 5'd5; step(); idle();
        wr_en[0] = 1; wr_tag[0] = 3'd1; wr_data[0] = 64'h11; step(); idle();
        commit_num = 3'd1; step(); idle();
        src_reg[0] = 5'd5; peek();
        chk("R8", "young ready", 64'(src_ready[0]), 64'd0);
        chk("R8", "young tag", 64'(src_tag[0]), 64'd2);
        idle();
        wr_en[0] = 1; wr_tag[0] = 3'd2; wr_data[0] = 64'h22; step(); idle();
        commit_num = 3'd4; step(); idle();
        src_reg[0] = 5'd5; peek();
        chk("R7", "retired value", src_data[0], 64'h22);
        idle();

        // R2 / R9: fill pool, refuse, flush, full pool returns
        alloc_req = 4'hf; alloc_rd = {5'd10, 5'd9, 5'd8, 5'd7}; step();
        step();
        peek();
        chk("R2", "full refuse", 64'(alloc_gnt), 64'h0);
        idle();
        wr_en[0] = 1; wr_tag[0] = 3'd3; wr_data[0] = 64'h77; step(); idle();
        flush = 1; alloc_req = 4'hf; alloc_rd = {5'd7, 5'd7, 5'd7, 5'd7};
        wr_en[1] = 1; wr_tag[1] = 3'd4; wr_data[1] = 64'h99; commit_num = 3'd4;
        step(); idle();
        src_reg[0] = 5'd7; src_reg[1] = 5'd8; alloc_req = 4'hf; peek();
        chk("R9", "flushed r7 ready", 64'(src_ready[0]), 64'd1);
        chk("R9", "flushed r7 value", src_data[0], 64'd0);
        chk("R9", "flushed r8 ready", 64'(src_ready[1]), 64'd1);
        chk("R9", "pool regrant", 64'(alloc_gnt), 64'hf);
        chk("R9", "regrant tag", 64'(alloc_tag[0]), 64'd3);
        idle();

        // Random traffic on few registers
        for (int cyc = 0; cyc < 4000; cyc++) begin
            int cand[$];
            idle();
            for (int k = 0; k < 4; k++) begin
                alloc_req[k] = ($urandom % 2) == 0;
                alloc_rd[k]  = 5'($urandom % 6);
                src_reg[k]   = 5'($urandom % 6);
            end
            for (int i = 0; i < q.size(); i++) if (!q[i].done) cand.push_back(q[i].tag);
            for (int k = 0; k < 4; k++) begin
                if (cand.size() > 0 && ($urandom % 2) == 0) begin
                    int p;
                    p = int'($urandom % cand.size());
                    wr_en[k] = 1; wr_tag[k] = 3'(cand[p]);
                    wr_data[k] = {$urandom, $urandom};
                    cand.delete(p);
                end
            end
            commit_num = 3'($urandom % 5);
            flush = ($urandom % 48) == 0;
            step();
        end

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule